// File: doc/BRIEF.md
# Clock Configuration Register Slave on a Two-Wire Serial Bus

This block sits inside a clock generator and holds its small set of configuration bytes. A host on a standard-mode (100 kbit/s or slower) two-wire serial bus writes or reads these bytes. The bus pins are oversampled on a fast system clock. The slave pulls the data line low through a single drive-low enable, and the whole register bank is presented in parallel to the rest of the device.

The framing uses no register address. A write carries a command byte and a count byte after the device address. Both are acknowledged and thrown away. The data bytes that follow fill the bank from byte 0 upward. A read first returns the number of implemented bytes and then streams the bank from byte 0 upward. The host can stop after any whole byte.

Top module: `i2ccfg_slave`

## Requirements
- R1: While reset is asserted the bank holds its defaults. With the default parameters, byte 0 is 0x06, bytes 1 and 2 are 0xFF, and bytes 3 to 5 are 0x00. Byte n sits at cfgRegs[8n+7:8n].
- R2: Only the address byte 0xD2 (write) and the address byte 0xD3 (read) are acknowledged. Any other address byte gets no acknowledge, and the slave ignores the bus until the next start.
- R3: On a write, the first two bytes after the address are acknowledged and do not change any register.
- R4: Each write data byte is acknowledged and stored in the next byte of the bank, starting at byte 0. Bits arrive MSB first. The bank only changes while SCL is low.
- R5: A stop after any whole byte ends the write. Bytes the write did not reach keep their previous values.
- R6: A read returns the byte count NUM_REGS (6 by default) first, then bank bytes from byte 0 upward, each MSB first.
- R7: A read that goes past the last implemented byte returns 0xFF.
- R8: Write data bytes past the last implemented byte are acknowledged and discarded.
- R9: When the host does not acknowledge a read byte, the slave releases SDA and sends nothing more.
- R10: The slave changes its SDA drive only while SCL is low, so it never creates a start or a stop.
- R11: A start, including a repeated start inside a transfer, restarts the framing at the address byte and moves the byte pointer back to byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset; loads the defaults |
| sclIn | input | 1 | Serial clock line as seen at the pin |
| sdaIn | input | 1 | Serial data line as seen at the pin |
| sdaDriveLow | output | 1 | When high, the pad pulls SDA low |
| cfgRegs | output | NUM_REGS*8 | Register bank, byte n at bits 8n+7:8n |

## Verification
The bench targets the framing corners. A command or count byte that leaked into the bank would overwrite byte 0. A read that skipped the count byte would shift every returned value by one position. A pointer that did not saturate would wrap, so extra write bytes would overwrite byte 0 and extra read bytes would return real data instead of 0xFF. The bench also issues a repeated start straight after a write. A pointer that is not cleared there would make the read start mid-bank. A slave that kept driving after the host's NACK would corrupt the stop.

// File: rtl/i2ccfg_pkg.sv
package i2ccfg_pkg;
  // Strobes from the bus controller to the register datapath
  typedef struct packed {
    logic       clrPtr;  // start seen: pointer back to byte 0
    logic       wrEn;    // store data at pointer, then advance
    logic       rdAdv;   // a bank byte was loaded for sending: advance
    logic [7:0] data;    // received data byte
  } cfgStrobe_t;
endpackage

// File: rtl/i2ccfg_ctrl.sv
module i2ccfg_ctrl
  import i2ccfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter logic [7:0] COUNT_VAL = 8'd6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdByte,
  output cfgStrobe_t stb,
  output logic       sdaDriveLow
);
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} state_t;
  localparam logic [1:0] K_ADDR = 2'd0;
  localparam logic [1:0] K_DATA = 2'd3;

  logic   sclMeta, sclS, sclD, sdaMeta, sdaS, sdaD;
  logic   sclRise, sclFall, startDet, stopDet;
  state_t state;
  logic [1:0] kind;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;
  logic       isRead, masterAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclMeta <= 1'b1; sclS <= 1'b1; sclD <= 1'b1;
      sdaMeta <= 1'b1; sdaS <= 1'b1; sdaD <= 1'b1;
    end else begin
      sclMeta <= sclIn; sclS <= sclMeta; sclD <= sclS;
      sdaMeta <= sdaIn; sdaS <= sdaMeta; sdaD <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; kind <= K_ADDR; bitCnt <= '0; shiftReg <= '0;
      isRead <= 1'b0; masterAck <= 1'b0; sdaDriveLow <= 1'b0; stb <= '0;
    end else begin
      stb <= '0;
      if (stopDet) begin
        state <= ST_IDLE;
        sdaDriveLow <= 1'b0;
      end else if (startDet) begin
        state <= ST_RX; kind <= K_ADDR; bitCnt <= '0;
        sdaDriveLow <= 1'b0;
        stb.clrPtr <= 1'b1;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise && bitCnt != 4'd8) begin
              shiftReg <= {shiftReg[6:0], sdaS};
              bitCnt   <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (kind == K_ADDR) begin
                if (shiftReg[7:1] == DEV_ADDR) begin
                  isRead <= shiftReg[0];
                  sdaDriveLow <= 1'b1;
                  state <= ST_RX_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sdaDriveLow <= 1'b1;
                state <= ST_RX_ACK;
                if (kind == K_DATA) begin
                  stb.wrEn <= 1'b1;
                  stb.data <= shiftReg;
                end
              end
            end
          end
          ST_RX_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (isRead) begin
                shiftReg <= COUNT_VAL;
                sdaDriveLow <= ~COUNT_VAL[7];
                state <= ST_TX;
              end else begin
                sdaDriveLow <= 1'b0;
                kind <= (kind == K_DATA) ? K_DATA : kind + 2'd1;
                state <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                sdaDriveLow <= 1'b0;
                state <= ST_TX_ACK;
              end else begin
                shiftReg <= {shiftReg[6:0], 1'b0};
                sdaDriveLow <= ~shiftReg[6];
                bitCnt <= bitCnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (sclRise) masterAck <= ~sdaS;
            if (sclFall) begin
              if (masterAck) begin
                shiftReg <= rdByte;
                sdaDriveLow <= ~rdByte[7];
                stb.rdAdv <= 1'b1;
                bitCnt <= '0;
                state <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2ccfg_regs.sv
module i2ccfg_regs
  import i2ccfg_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter logic [NUM_REGS*8-1:0] RESET_VALUES = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfgStrobe_t            stb,
  output logic [7:0]            rdByte,
  output logic [NUM_REGS*8-1:0] cfgRegs
);
  localparam int PTR_W = $clog2(NUM_REGS + 1);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

  logic [PTR_W-1:0] ptr;
  logic [7:0] regBank [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (stb.clrPtr) ptr <= '0;
    else if ((stb.wrEn || stb.rdAdv) && ptr != PTR_END) ptr <= ptr + 1'b1;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_byte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regBank[i] <= RESET_VALUES[i*8 +: 8];
      else if (stb.wrEn && ptr == PTR_W'(i)) regBank[i] <= stb.data;
    end
    assign cfgRegs[i*8 +: 8] = regBank[i];
  end

  always_comb begin
    rdByte = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr == PTR_W'(i)) rdByte = regBank[i];
  end
endmodule

// File: rtl/i2ccfg_slave.sv
module i2ccfg_slave
  import i2ccfg_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [NUM_REGS*8-1:0] RESET_VALUES = 48'h0000_00FF_FF06
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaDriveLow,
  output logic [NUM_REGS*8-1:0] cfgRegs
);
  cfgStrobe_t ctrlStb;
  logic [7:0] rdByte;

  i2ccfg_ctrl #(.DEV_ADDR(DEV_ADDR), .COUNT_VAL(8'(NUM_REGS))) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdByte(rdByte), .stb(ctrlStb), .sdaDriveLow(sdaDriveLow)
  );

  i2ccfg_regs #(.NUM_REGS(NUM_REGS), .RESET_VALUES(RESET_VALUES)) u_regs (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .rdByte(rdByte), .cfgRegs(cfgRegs)
  );
endmodule

// File: rtl/i2ccfg_chk.sv
module i2ccfg_chk
  import i2ccfg_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter logic [NUM_REGS*8-1:0] RESET_VALUES = '0
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaDriveLow,
  input logic [NUM_REGS*8-1:0] cfgRegs,
  input cfgStrobe_t            stb
);
  // R1
  reset_default_chk: assert property (@(posedge clk)
    !rstN |=> (cfgRegs == RESET_VALUES));

  // R10
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDriveLow != $past(sdaDriveLow)) |-> !sclIn);

  // R4
  bank_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRegs != $past(cfgRegs)) |-> !sclIn);

  // R4
  store_acked_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> sdaDriveLow);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.clrPtr, stb.wrEn, stb.rdAdv}));
endmodule

bind i2ccfg_slave i2ccfg_chk #(.NUM_REGS(NUM_REGS), .RESET_VALUES(RESET_VALUES)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .cfgRegs(cfgRegs), .stb(ctrlStb)
);

// File: tb/i2ccfg_slave_bench.sv
module i2ccfg_slave_bench;
  localparam int Q = 25;
  localparam logic [47:0] DEFV = 48'h0000_00FF_FF06;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaBus;
  logic sdaDriveLow;
  logic [47:0] cfgRegs;

  assign sdaBus = sdaM & ~sdaDriveLow;

  i2ccfg_slave u_i2ccfg_slave (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .cfgRegs(cfgRegs)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int r10Viol = 0;

  typedef struct { logic [7:0] val; string req; } expItem_t;
  expItem_t expQ[$];
  logic [7:0] obsVal;
  event obsEv;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; wt(Q); scl = 1'b1; wt(Q); sdaM = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; wt(Q); scl = 1'b1; wt(Q); sdaM = 1'b1; wt(Q);
  endtask

  task automatic sendBit(logic b);
    sdaM = b; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; wt(Q); scl = 1'b1; wt(Q); b = sdaBus; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic writeByte(logic [7:0] v, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(nb);
    ack = ~nb;
  endtask

  // Driver side: push an expectation, then clock the byte in
  task automatic expectRead(logic [7:0] v, string req, logic giveAck);
    logic [7:0] got;
    logic b;
    expQ.push_back('{v, req});
    for (int i = 7; i >= 0; i--) begin recvBit(b); got[i] = b; end
    obsVal = got;
    ->obsEv;
    sendBit(giveAck ? 1'b0 : 1'b1);
  endtask

  // Monitor side: pop and compare each byte the slave sends
  initial begin
    forever begin
      @(obsEv);
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 unexpected byte actual=%0h expected=none", obsVal);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.req, {56'd0, obsVal}, {56'd0, e.val});
      end
    end
  end

  // R10 watcher: slave drive must not move while SCL is high
  always @(posedge clk) begin
    if (rstN && scl && (sdaDriveLow !== $past(sdaDriveLow))) r10Viol++;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    wt(10);
    // R1 defaults during and after reset
    check("R1", {16'd0, cfgRegs}, {16'd0, DEFV});
    rstN = 1'b1;
    wt(20);
    check("R1", {16'd0, cfgRegs}, {16'd0, DEFV});

    // Write three data bytes
    busStart();
    writeByte(8'hD2, ack); check("R2", {63'd0, ack}, 64'd1);
    writeByte(8'h55, ack); check("R3", {63'd0, ack}, 64'd1);
    writeByte(8'h03, ack); check("R3", {63'd0, ack}, 64'd1);
    writeByte(8'hA1, ack); check("R4", {63'd0, ack}, 64'd1);
    writeByte(8'hB2, ack); check("R4", {63'd0, ack}, 64'd1);
    writeByte(8'hC3, ack); check("R4", {63'd0, ack}, 64'd1);
    busStop(); wt(10);
    check("R5", {16'd0, cfgRegs}, {16'd0, 48'h0000_00C3_B2A1});

    // Foreign address is ignored
    busStart();
    writeByte(8'hA0, ack); check("R2", {63'd0, ack}, 64'd0);
    writeByte(8'h12, ack); check("R2", {63'd0, ack}, 64'd0);
    busStop(); wt(10);
    check("R2", {16'd0, cfgRegs}, {16'd0, 48'h0000_00C3_B2A1});

    // Write with command and count only
    busStart();
    writeByte(8'hD2, ack);
    writeByte(8'hEE, ack); check("R3", {63'd0, ack}, 64'd1);
    writeByte(8'h77, ack); check("R3", {63'd0, ack}, 64'd1);
    busStop(); wt(10);
    check("R3", {16'd0, cfgRegs}, {16'd0, 48'h0000_00C3_B2A1});

    // Read full bank plus overrun
    busStart();
    writeByte(8'hD3, ack); check("R2", {63'd0, ack}, 64'd1);
    expectRead(8'd6,  "R6", 1'b1);
    expectRead(8'hA1, "R6", 1'b1);
    expectRead(8'hB2, "R6", 1'b1);
    expectRead(8'hC3, "R6", 1'b1);
    expectRead(8'h00, "R6", 1'b1);
    expectRead(8'h00, "R6", 1'b1);
    expectRead(8'h00, "R6", 1'b1);
    expectRead(8'hFF, "R7", 1'b1);
    expectRead(8'hFF, "R7", 1'b0);
    wt(10);
    check("R9", {63'd0, sdaDriveLow}, 64'd0);
    busStop(); wt(10);
    check("R9", {63'd0, sdaDriveLow}, 64'd0);

    // Write past the end
    busStart();
    writeByte(8'hD2, ack);
    writeByte(8'h00, ack);
    writeByte(8'h08, ack);
    for (int i = 1; i <= 8; i++) begin
      writeByte(8'(i * 17), ack);
      check("R8", {63'd0, ack}, 64'd1);
    end
    busStop(); wt(10);
    check("R8", {16'd0, cfgRegs}, {16'd0, 48'h6655_4433_2211});

    // Repeated start from write into read
    busStart();
    writeByte(8'hD2, ack);
    writeByte(8'h00, ack);
    writeByte(8'h01, ack);
    writeByte(8'h9A, ack); check("R4", {63'd0, ack}, 64'd1);
    busStart();
    writeByte(8'hD3, ack); check("R11", {63'd0, ack}, 64'd1);
    expectRead(8'd6,  "R11", 1'b1);
    expectRead(8'h9A, "R11", 1'b1);
    expectRead(8'h22, "R11", 1'b0);
    busStop(); wt(10);
    check("R5", {16'd0, cfgRegs}, {16'd0, 48'h6655_4433_229A});

    check("R10", r10Viol, 0);
    check("R6", expQ.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule